// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the two lowest address bits for a four-beat synchronous burst. A load strobe captures a two-bit start offset from the external address. Each advance strobe moves to the next beat. A cycle with no advance is a wait cycle: the offset holds and the burst stays open. The caller concatenates the offset output with its own registered upper address bits. No carry from this block ever reaches those upper bits.

A mode input selects the beat order. In interleaved order, beat k is the start offset XOR k. In linear order, beat k is the start offset plus k, modulo four. The block also has a two-bit beat count and a flag for the first beat. A separate controller decides from the bus control pins whether a cycle loads or advances.

Top module: `burst_seq`

## Requirements
- R1: While rst_ni is low, offset_o is 00, beat_o is 0 and first_o is 1.
- R2: A clock edge with load_i high captures start_i. From the next cycle, offset_o equals the captured start, beat_o is 0 and first_o is 1.
- R3: load_i has priority over advance. An edge with load_i high and adv_ni low behaves exactly like a load.
- R4: An edge with load_i low and adv_ni high is a wait cycle. offset_o and beat_o keep their values and the burst continues afterwards from the held beat.
- R5: With mode_i = 1 (interleaved), offset_o equals start XOR beat_o. A start of 01 gives 01, 00, 11, 10.
- R6: With mode_i = 0 (linear), offset_o equals (start + beat_o) mod 4. A start of 01 gives 01, 10, 11, 00.
- R7: An edge with load_i low and adv_ni low increments beat_o by one, modulo 4.
- R8: An advance from beat 3 wraps beat_o to 0. offset_o returns to the captured start and first_o rises again. No carry leaves the two-bit offset.
- R9: first_o is 1 exactly when beat_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| load_i | input | 1 | Capture start_i and begin a burst |
| start_i | input | 2 | External start offset (low address bits) |
| adv_ni | input | 1 | Active-low advance; high means wait |
| offset_o | output | 2 | Current low address bits |
| beat_o | output | 2 | Current beat number within the burst |
| first_o | output | 1 | High on the first beat |

## Verification
A corrupted captured start register shows at offset_o one cycle after the load. It shows for every remaining beat, because each later offset is derived from that start. A beat counter that skips, sticks or fails to wrap first appears on beat_o and first_o at the faulty edge. In linear order, a missed step and a repeated offset look the same, so the bench checks beat_o and offset_o together after every edge. A wrong order select changes offset_o only at beats 1 and 3 for some starts, so the bench sweeps all four starts in both modes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int unsigned OFS_W = 2;
  typedef logic [OFS_W-1:0] ofs_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTLV  = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     start_o <= '0;
    else if (load_i) start_o <= start_i;
  end

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_i) |-> start_o == $past(start_i));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_ni,
  output logic [W-1:0] beat_o
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  // load beats advance; wrap stays inside the group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (load_i)  beat_o <= '0;
    else if (!adv_ni) beat_o <= beat_o + 1'b1;
  end

  a_r3_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_i) |-> beat_o == '0);
  a_r4_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(load_i) && $past(adv_ni) |-> $stable(beat_o));
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(load_i) && !$past(adv_ni) && $past(beat_o) == LAST
    |-> beat_o == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic         mode_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  output logic [W-1:0] ofs_o
);
  logic [W-1:0] intlv, linear;

  assign intlv  = start_i ^ beat_i;
  assign linear = start_i + beat_i;  // truncated: no carry out
  assign ofs_o  = (order_e'(mode_i) == ORD_INTLV) ? intlv : linear;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       load_i,
  input  logic [1:0] start_i,
  input  logic       adv_ni,
  output logic [1:0] offset_o,
  output logic [1:0] beat_o,
  output logic       first_o
);
  ofs_t start_q, beat_q;

  burst_start_reg #(.W(OFS_W)) u_start (
    .clk_i, .rst_ni, .load_i, .start_i, .start_o(start_q)
  );

  burst_beat_ctr #(.W(OFS_W)) u_beat (
    .clk_i, .rst_ni, .load_i, .adv_ni, .beat_o(beat_q)
  );

  burst_order_map #(.W(OFS_W)) u_map (
    .mode_i, .start_i(start_q), .beat_i(beat_q), .ofs_o(offset_o)
  );

  assign beat_o  = beat_q;
  assign first_o = (beat_q == '0);

  a_r4_wait_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(load_i) && $past(adv_ni) && $stable(mode_i)
    |-> $stable(offset_o));
  a_r2_first_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(load_i) |-> first_o && offset_o == $past(start_i));
  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(load_i) && !$past(adv_ni)
    |-> beat_o == 2'($past(beat_o) + 1));
endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b1;
  logic       load_i = 1'b0;
  logic [1:0] start_i = 2'b00;
  logic       adv_ni = 1'b1;
  logic [1:0] offset_o, beat_o;
  logic       first_o;

  int n_chk = 0, n_bad = 0;
  logic [1:0] m_start, m_beat;

  always #4 clk = ~clk;

  burst_seq dut (.clk_i(clk), .rst_ni, .mode_i, .load_i, .start_i, .adv_ni,
                 .offset_o, .beat_o, .first_o);

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  function automatic logic [1:0] exp_ofs(logic m, logic [1:0] s, logic [1:0] b);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic chk(string req, logic [1:0] ofs, logic [1:0] bt);
    n_chk++;
    if (offset_o !== ofs || beat_o !== bt || first_o !== (bt == 2'd0)) begin
      n_bad++;
      $display("FAIL %s: actual ofs=%b beat=%0d first=%b expected ofs=%b beat=%0d first=%b",
               req, offset_o, beat_o, first_o, ofs, bt, bt == 2'd0);
    end
  endtask

  // drive at negedge, apply one edge, sample 1 ns later
  task automatic cyc(logic ld, logic [1:0] s, logic an);
    @(negedge clk);
    load_i = ld; start_i = s; adv_ni = an;
    @(posedge clk);
    #1;
    if (ld) begin m_start = s; m_beat = 2'd0; end
    else if (!an) m_beat = m_beat + 2'd1;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    #1 chk("R1", 2'b00, 2'd0);
    cyc(1'b0, 2'b00, 1'b0);
    chk("R1", 2'b00, 2'd0);
    @(negedge clk) rst_ni = 1'b1;
    m_start = 2'b00; m_beat = 2'd0;
  endtask

  task automatic t_sweep(logic m);
    mode_i = m;
    for (int s = 0; s < 4; s++) begin
      cyc(1'b1, 2'(s), 1'b1);
      chk("R2", 2'(s), 2'd0);
      for (int k = 1; k < 5; k++) begin
        cyc(1'b0, 2'b00, 1'b0);
        chk(m ? "R5" : "R6", exp_ofs(m, 2'(s), 2'(k)), 2'(k));
      end
      chk("R8", 2'(s), 2'd0);
    end
  endtask

  task automatic t_literal;
    logic [1:0] il[4] = '{2'b01, 2'b00, 2'b11, 2'b10};
    logic [1:0] ln[4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    mode_i = 1'b1;
    cyc(1'b1, 2'b01, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R5", il[k], 2'(k));
      cyc(1'b0, 2'b00, 1'b0);
    end
    mode_i = 1'b0;
    cyc(1'b1, 2'b01, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R6", ln[k], 2'(k));
      cyc(1'b0, 2'b00, 1'b0);
    end
  endtask

  task automatic t_wait;
    mode_i = 1'b0;
    cyc(1'b1, 2'b10, 1'b1);
    cyc(1'b0, 2'b11, 1'b0);
    chk("R7", 2'b11, 2'd1);
    cyc(1'b0, 2'b01, 1'b1);
    chk("R4", 2'b11, 2'd1);
    cyc(1'b0, 2'b00, 1'b1);
    chk("R4", 2'b11, 2'd1);
    cyc(1'b0, 2'b00, 1'b0);
    chk("R4", 2'b00, 2'd2);
    chk("R9", exp_ofs(1'b0, m_start, m_beat), m_beat);
  endtask

  task automatic t_priority;
    mode_i = 1'b1;
    cyc(1'b1, 2'b00, 1'b1);
    cyc(1'b0, 2'b00, 1'b0);
    cyc(1'b0, 2'b00, 1'b0);
    chk("R7", 2'b10, 2'd2);
    cyc(1'b1, 2'b11, 1'b0);
    chk("R3", 2'b11, 2'd0);
    cyc(1'b0, 2'b00, 1'b0);
    chk("R3", 2'b10, 2'd1);
  endtask

  initial begin
    t_reset();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_literal();
    t_wait();
    t_priority();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule